// File: doc/BRIEF.md
# Two-Level Masked Interrupt Arbiter

This block chooses which pending interrupt a small CPU takes next. Two mask flags gate the choice. The main flag, I, blocks ordinary requests. The second flag, UI, together with I, also blocks requests that have been raised to the upper level. Each of the maskable request lines has a level bit in a writable register. A line at level 1 gets through a partial mask and outranks every line at level 0. A non-maskable request and an address-break request always get through. A separate group of auxiliary sources (key input, wakeup, transfer end) obeys only the main flag.

Requests are level-held. While the arbiter is idle it looks at them on every clock. When at least one request may be taken, it raises a one-cycle accept strobe together with the index of the winner. It then waits for the CPU's acknowledge. The acknowledge marks the start of exception handling and sets both flags, which moves the block into its most restrictive state. Software can write the flags at any time to open the mask fully or partly.

Top module: `irq_level_arb`

## Requirements
- R1: After reset accept is 0, I and UI are both 1, and every maskable line is at level 0.
- R2: A non-maskable request (index 0) and an address-break request (index 1) are accepted whatever the values of I and UI.
- R3: A maskable line IRQk at level 0 (index 2+k) is accepted only while I is 0.
- R4: A maskable line at level 1 is accepted while I is 0 or UI is 0. It is held only when both flags are 1.
- R5: An auxiliary source j (index 10+j) is accepted only while I is 0. UI and the level register have no effect on it.
- R6: When several requests are eligible, the winner is chosen in this order: non-maskable, then address break, then level 1 lines by ascending k, then level 0 lines by ascending k, then auxiliary sources by ascending j.
- R7: accept rises on the clock edge after an eligible request is seen in the idle state. It stays high for exactly one cycle, and no new accept follows until an acknowledge arrives.
- R8: An acknowledge received while waiting sets I and UI to 1 on the next edge. An acknowledge received while idle changes nothing.
- R9: A flag write loads I and UI on the next edge. When a flag write and a waiting acknowledge fall in the same cycle, the acknowledge wins and both flags become 1.
- R10: A level write loads the whole level register, with bit k as the level of IRQk (1 = upper level). The new level takes effect on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_req | input | 1 | Non-maskable request |
| brk_req | input | 1 | Address-break request |
| irq_req | input | 8 | Maskable request lines |
| aux_req | input | 3 | Auxiliary sources gated only by I |
| lvl_we | input | 1 | Level register write enable |
| lvl_wdata | input | 8 | New level bits, bit k for IRQk |
| flag_we | input | 1 | Flag write enable |
| flag_i_wdata | input | 1 | New value of I |
| flag_ui_wdata | input | 1 | New value of UI |
| ack | input | 1 | CPU acknowledge that exception handling has started |
| accept | output | 1 | One-cycle strobe for a taken request |
| win_idx | output | 4 | Index of the taken source |
| flag_i | output | 1 | Current I flag |
| flag_ui | output | 1 | Current UI flag |

## Verification
The arbiter is tried with each of the three mask states (both flags clear, only I set, both set) and with mixed request sets. Each set pits one source class against another. These runs show whether a level 0 line, a level 1 line and an auxiliary source are each gated by the right flags, and whether the order between the classes holds. Other directed runs hold a request over several cycles to separate the one-shot strobe from a repeating one. They also give the acknowledge alone, together with a flag write, or while idle, to show that only an acknowledge received while waiting touches the flags.

// File: rtl/irq_level_arb.sv
module irq_level_arb #(
  parameter int N_IRQ = 8,
  parameter int N_AUX = 3,
  localparam int N_SRC = 2 + N_IRQ + N_AUX,
  localparam int IW = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_req,
  input  logic             brk_req,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_AUX-1:0] aux_req,
  input  logic             lvl_we,
  input  logic [N_IRQ-1:0] lvl_wdata,
  input  logic             flag_we,
  input  logic             flag_i_wdata,
  input  logic             flag_ui_wdata,
  input  logic             ack,
  output logic             accept,
  output logic [IW-1:0]    win_idx,
  output logic             flag_i,
  output logic             flag_ui
);
  localparam int IRQ_BASE = 2;
  localparam int AUX_BASE = 2 + N_IRQ;

  logic [N_IRQ-1:0] lvl;
  logic             waiting;
  logic             hit;
  logic [IW-1:0]    sel;

  wire [N_IRQ-1:0] irq_hi = irq_req & lvl & {N_IRQ{~(flag_i & flag_ui)}};
  wire [N_IRQ-1:0] irq_lo = irq_req & ~lvl & {N_IRQ{~flag_i}};
  wire [N_AUX-1:0] aux_ok = aux_req & {N_AUX{~flag_i}};

  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int j = N_AUX - 1; j >= 0; j--)
      if (aux_ok[j]) begin
        hit = 1'b1;
        sel = IW'(AUX_BASE + j);
      end
    for (int k = N_IRQ - 1; k >= 0; k--)
      if (irq_lo[k]) begin
        hit = 1'b1;
        sel = IW'(IRQ_BASE + k);
      end
    for (int k = N_IRQ - 1; k >= 0; k--)
      if (irq_hi[k]) begin
        hit = 1'b1;
        sel = IW'(IRQ_BASE + k);
      end
    if (brk_req) begin
      hit = 1'b1;
      sel = IW'(1);
    end
    if (nmi_req) begin
      hit = 1'b1;
      sel = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting <= 1'b0;
      accept  <= 1'b0;
      win_idx <= '0;
    end else begin
      accept <= 1'b0;
      if (waiting) begin
        if (ack) waiting <= 1'b0;
      end else if (hit) begin
        waiting <= 1'b1;
        accept  <= 1'b1;
        win_idx <= sel;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_i  <= 1'b1;
      flag_ui <= 1'b1;
    end else if (waiting && ack) begin
      flag_i  <= 1'b1;
      flag_ui <= 1'b1;
    end else if (flag_we) begin
      flag_i  <= flag_i_wdata;
      flag_ui <= flag_ui_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl <= '0;
    else if (lvl_we) lvl <= lvl_wdata;
  end
endmodule

module irq_level_arb_chk #(
  parameter int N_IRQ = 8,
  parameter int IW = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             nmi_req,
  input logic             brk_req,
  input logic [N_IRQ-1:0] irq_req,
  input logic [N_IRQ-1:0] lvl,
  input logic             waiting,
  input logic             ack,
  input logic             accept,
  input logic [IW-1:0]    win_idx,
  input logic             flag_i,
  input logic             flag_ui
);
  AST_ACC_PULSE: assert property (@(posedge clk) disable iff (!rst_n) accept |=> !accept); // R7
  AST_ACC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) accept |-> waiting); // R7
  AST_ACK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) (waiting && ack) |=> (flag_i && flag_ui)); // R8
  AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n) (!waiting && nmi_req) |=> (accept && win_idx == '0)); // R2
  AST_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n) (!waiting && flag_i && flag_ui) |=> (!accept || win_idx < IW'(2))); // R4
  AST_LO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!waiting && flag_i && !nmi_req && !brk_req && !(|(irq_req & lvl))) |=> !accept); // R3
endmodule

bind irq_level_arb irq_level_arb_chk #(.N_IRQ(N_IRQ), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .brk_req(brk_req), .irq_req(irq_req),
  .lvl(lvl), .waiting(waiting), .ack(ack), .accept(accept), .win_idx(win_idx),
  .flag_i(flag_i), .flag_ui(flag_ui)
);

// File: tb/test_irq_level_arb.sv
module test_irq_level_arb;
  localparam int CLK_P = 10;
  localparam int NV = 14;
  // {lvl[8], I, UI, nmi, brk, irq[8], aux[3], exp_acc, exp_idx[4]}
  localparam logic [27:0] VEC [NV] = '{
    {8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 3'h7, 1'b0, 4'd0},  // R3 R5 all masked
    {8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 3'h7, 1'b1, 4'd0},  // R2
    {8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'hFF, 3'h7, 1'b1, 4'd1},  // R2
    {8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h0A, 3'h0, 1'b1, 4'd3},  // R3
    {8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 3'h6, 1'b1, 4'd11}, // R5
    {8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 3'h7, 1'b0, 4'd0},  // R5 UI no effect
    {8'h0C, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 3'h7, 1'b1, 4'd4},  // R4 R10
    {8'h0C, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 3'h7, 1'b0, 4'd0},  // R4
    {8'h0C, 1'b0, 1'b1, 1'b0, 1'b0, 8'h0B, 3'h0, 1'b1, 4'd5},  // R6
    {8'h0C, 1'b0, 1'b0, 1'b0, 1'b0, 8'h09, 3'h0, 1'b1, 4'd5},  // R6
    {8'h80, 1'b0, 1'b0, 1'b0, 1'b0, 8'h81, 3'h7, 1'b1, 4'd9},  // R6
    {8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h80, 3'h1, 1'b1, 4'd9},  // R6
    {8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h80, 3'h0, 1'b0, 4'd0},  // R3
    {8'h80, 1'b1, 1'b0, 1'b0, 1'b1, 8'h80, 3'h0, 1'b1, 4'd1}   // R6
  };

  logic clk = 0, rst_n = 0;
  logic nmi_req = 0, brk_req = 0, lvl_we = 0, flag_we = 0, flag_i_wdata = 0, flag_ui_wdata = 0, ack = 0;
  logic [7:0] irq_req = '0, lvl_wdata = '0;
  logic [2:0] aux_req = '0;
  logic accept, flag_i, flag_ui;
  logic [3:0] win_idx;
  int total = 0, bad = 0;

  irq_level_arb i_irq_level_arb (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .brk_req(brk_req), .irq_req(irq_req),
    .aux_req(aux_req), .lvl_we(lvl_we), .lvl_wdata(lvl_wdata), .flag_we(flag_we),
    .flag_i_wdata(flag_i_wdata), .flag_ui_wdata(flag_ui_wdata), .ack(ack),
    .accept(accept), .win_idx(win_idx), .flag_i(flag_i), .flag_ui(flag_ui)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_flags(input logic fi, input logic fu);
    flag_we = 1; flag_i_wdata = fi; flag_ui_wdata = fu;
    step();
    flag_we = 0;
  endtask

  initial begin
    #(CLK_P * 100000);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 2 + 1);
    chk(accept == 0, "R1 accept in reset", accept, 0);
    chk(flag_i && flag_ui, "R1 flags in reset", {flag_i, flag_ui}, 3);
    rst_n = 1;
    step();
    // R1: levels reset to 0, so a partial mask blocks every line
    wr_flags(1, 0);
    irq_req = 8'hFF;
    step();
    chk(accept == 0, "R1 levels reset to 0", accept, 0);
    irq_req = '0;
    step();

    for (int v = 0; v < NV; v++) begin
      lvl_we = 1; lvl_wdata = VEC[v][27:20];
      flag_we = 1; flag_i_wdata = VEC[v][19]; flag_ui_wdata = VEC[v][18];
      step();
      lvl_we = 0; flag_we = 0;
      nmi_req = VEC[v][17]; brk_req = VEC[v][16];
      irq_req = VEC[v][15:8]; aux_req = VEC[v][7:5];
      chk(accept == 0, "R7 no early accept", accept, 0);
      step();
      chk(accept == VEC[v][4], $sformatf("R6 vec%0d accept", v), accept, VEC[v][4]);
      if (VEC[v][4])
        chk(win_idx == VEC[v][3:0], $sformatf("R6 vec%0d index", v), win_idx, VEC[v][3:0]);
      nmi_req = 0; brk_req = 0; irq_req = '0; aux_req = '0;
      if (accept) begin
        ack = 1;
        step();
        ack = 0;
        chk(flag_i && flag_ui, "R8 ack sets flags", {flag_i, flag_ui}, 3);
      end
      step();
    end

    // R7: held request gives a single strobe until acknowledged
    lvl_we = 1; lvl_wdata = '0; step(); lvl_we = 0;
    wr_flags(0, 0);
    irq_req = 8'h01;
    step();
    chk(accept && win_idx == 2, "R7 first strobe", {accept, win_idx}, 18);
    step();
    chk(accept == 0, "R7 strobe one cycle", accept, 0);
    step();
    chk(accept == 0, "R7 no repeat while waiting", accept, 0);
    ack = 1; step(); ack = 0;
    chk(flag_i && flag_ui, "R8 ack while waiting", {flag_i, flag_ui}, 3);
    chk(accept == 0, "R7 no accept in ack cycle", accept, 0);
    step();
    chk(accept == 0, "R3 held after ack", accept, 0);
    // R9: write opens mask, then write and ack collide
    wr_flags(0, 1);
    chk(accept == 0, "R9 write takes effect next edge", accept, 0);
    step();
    chk(accept == 1, "R9 write opened mask", accept, 1);
    irq_req = '0;
    ack = 1; flag_we = 1; flag_i_wdata = 0; flag_ui_wdata = 0;
    step();
    ack = 0; flag_we = 0;
    chk(flag_i && flag_ui, "R9 ack beats write", {flag_i, flag_ui}, 3);
    // R8: acknowledge while idle is ignored
    wr_flags(0, 0);
    ack = 1; step(); ack = 0;
    chk(!flag_i && !flag_ui, "R8 idle ack ignored", {flag_i, flag_ui}, 0);
    step();
    chk(accept == 0, "R8 idle ack no strobe", accept, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule